// File: doc/BRIEF.md
# CAN controller mode and recovery control

This block holds the operating-mode control register of a CAN FD controller and the sequencer that brings a node back from bus-off. Software reads and writes the register through a plain 16-bit port. The block decodes one operating mode from the register and the core-enable input: configuration, normal, sleep, loopback or snoop. It also drives a set of control strobes for the protocol engine: forced-recessive transmit, ACK suppression, error-counter clear, bit-rate-switch override, single-shot transmit and protocol-exception disable.

Write permission depends on the field and on the node's state. Most option fields are frozen while the core is enabled. The manual recovery request can only be written while the node is bus-off, and it clears itself. The sleep request is cleared by a wake-up event. Bus-off recovery starts either from the manual request or from the automatic-recovery option. Once started, it counts runs of consecutive recessive sampled bits and then pulses a done strobe, which tells the surrounding logic to leave bus-off.

Top module: `can_mode_ctrl`

## Requirements
- R1: A hard reset (rst_n low) clears every field, and so does a software reset (sw_rst high at a clock edge, effective at that edge). Bits 15:8 of rdata always read 0.
- R2: Register layout: bit 0 sleep, bit 1 loopback, bit 2 snoop, bit 3 rate-switch override, bit 4 no-retransmit, bit 5 exception disable, bit 6 manual recovery, bit 7 auto recovery. Bits 1 to 5 and bit 7 take the written value only when wr_en is high while core_en is 0. Otherwise they keep their value.
- R3: Bit 0 takes a write at any time. A wake pulse clears it at the next edge, and wake wins over a write made in the same cycle.
- R4: Bit 6 takes a write only when bus_off=1 and core_en=1. It is cleared at the next edge whenever bus_off=0 or core_en=0.
- R5: mode encoding: 0 configuration, 1 normal, 2 sleep, 3 loopback, 4 snoop. With core_en=0 the mode is 0. With core_en=1 and exactly one of bits 0..2 set, the mode is that bit's mode. With none set, the mode is 1.
- R6: When two or more of bits 0..2 are set, illegal_mode is 1 and mode is 0. No mode bit is given priority over another.
- R7: In snoop mode, tx_recessive, ack_suppress and err_cnt_clear are all 1. In every other mode they are all 0.
- R8: brs_override, single_shot and pee_disable follow bits 3, 4 and 5.
- R9: Recovery runs only while bus_off=1, core_en=1, and bit 7 or bit 6 is set. Bit 7 starts it whatever bit 6 holds. With both clear, no done pulse ever occurs.
- R10: While recovery runs, each bit_tick with rx_bit=1 extends a recessive run and rx_bit=0 restarts the run. After REC_SEQS completed runs of IDLE_BITS, rec_done is high for exactly one cycle, in the cycle after the final tick. Bit 6 reads 0 from the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hard reset |
| core_en | input | 1 | Core enable |
| sw_rst | input | 1 | Synchronous software reset |
| bus_off | input | 1 | Node is in bus-off state |
| wake | input | 1 | Wake-up event pulse |
| rx_bit | input | 1 | Sampled bus bit, 1 = recessive |
| bit_tick | input | 1 | Qualifies rx_bit for one cycle per bit time |
| wr_en | input | 1 | Register write strobe |
| wdata | input | 16 | Register write data |
| rdata | output | 16 | Current register contents |
| mode | output | 3 | Decoded operating mode |
| illegal_mode | output | 1 | More than one mode bit set |
| tx_recessive | output | 1 | Force transmit to recessive |
| ack_suppress | output | 1 | Do not drive ACK |
| err_cnt_clear | output | 1 | Hold error counters at zero |
| brs_override | output | 1 | Send at nominal rate only |
| single_shot | output | 1 | One transmission attempt |
| pee_disable | output | 1 | Protocol-exception handling disabled |
| rec_active | output | 1 | Recovery sequencer running |
| rec_done | output | 1 | One-cycle recovery-complete pulse |

## Verification
The assertions assume that bus_off is driven by surrounding logic that, in normal use, drops it soon after rec_done. They also assume that wake, sw_rst and bit_tick are synchronous single-cycle strobes. The stimulus changes every input a short time after the rising edge and holds bit_tick for exactly one cycle. The register sweep keeps bit_tick low, so the sequencer cannot fire during it while bus_off and the recovery bits take arbitrary values. The bench drops bus_off itself after each recovery has been checked.

// File: rtl/can_mode_ctrl.sv
module can_mode_ctrl #(
  parameter int IDLE_BITS = 11,
  parameter int REC_SEQS  = 128
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        core_en,
  input  logic        sw_rst,
  input  logic        bus_off,
  input  logic        wake,
  input  logic        rx_bit,
  input  logic        bit_tick,
  input  logic        wr_en,
  input  logic [15:0] wdata,
  output logic [15:0] rdata,
  output logic [2:0]  mode,
  output logic        illegal_mode,
  output logic        tx_recessive,
  output logic        ack_suppress,
  output logic        err_cnt_clear,
  output logic        brs_override,
  output logic        single_shot,
  output logic        pee_disable,
  output logic        rec_active,
  output logic        rec_done
);
  localparam int RUN_W = $clog2(IDLE_BITS + 1);
  localparam int SEQ_W = $clog2(REC_SEQS + 1);
  localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(IDLE_BITS - 1);
  localparam logic [SEQ_W-1:0] SEQ_LAST = SEQ_W'(REC_SEQS - 1);
  localparam logic [2:0] M_CFG = 3'd0, M_NORMAL = 3'd1, M_SLEEP = 3'd2,
                         M_LOOP = 3'd3, M_SNOOP = 3'd4;

  logic sleep_q, lback_q, snoop_q, brsd_q, dar_q, dpee_q, sbr_q, abr_q;
  logic [RUN_W-1:0] run_q;
  logic [SEQ_W-1:0] seq_q;
  logic done_q;

  wire cfg_wr = wr_en && !core_en;
  wire sbr_wr = wr_en && bus_off && core_en;
  wire sbr_clr = !bus_off || !core_en || done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {abr_q, sbr_q, dpee_q, dar_q, brsd_q, snoop_q, lback_q, sleep_q} <= '0;
    end else if (sw_rst) begin
      {abr_q, sbr_q, dpee_q, dar_q, brsd_q, snoop_q, lback_q, sleep_q} <= '0;
    end else begin
      if (cfg_wr) begin
        lback_q <= wdata[1];
        snoop_q <= wdata[2];
        brsd_q  <= wdata[3];
        dar_q   <= wdata[4];
        dpee_q  <= wdata[5];
        abr_q   <= wdata[7];
      end
      if (wake)        sleep_q <= 1'b0;
      else if (wr_en)  sleep_q <= wdata[0];
      if (sbr_clr)     sbr_q <= 1'b0;
      else if (sbr_wr) sbr_q <= wdata[6];
    end
  end

  assign rec_active = bus_off && core_en && (abr_q || sbr_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= '0;
      seq_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (sw_rst || !rec_active) begin
        run_q <= '0;
        seq_q <= '0;
      end else if (bit_tick) begin
        if (!rx_bit) begin
          run_q <= '0;
        end else if (run_q == RUN_LAST) begin
          run_q <= '0;
          if (seq_q == SEQ_LAST) begin
            seq_q  <= '0;
            done_q <= 1'b1;
          end else begin
            seq_q <= seq_q + 1'b1;
          end
        end else begin
          run_q <= run_q + 1'b1;
        end
      end
    end
  end

  assign rec_done = done_q;

  assign illegal_mode = (sleep_q && lback_q) || (sleep_q && snoop_q) || (lback_q && snoop_q);

  always_comb begin
    mode = M_CFG;
    if (core_en && !illegal_mode) begin
      if (sleep_q)      mode = M_SLEEP;
      else if (lback_q) mode = M_LOOP;
      else if (snoop_q) mode = M_SNOOP;
      else              mode = M_NORMAL;
    end
  end

  wire in_snoop = (mode == M_SNOOP);
  assign tx_recessive  = in_snoop;
  assign ack_suppress  = in_snoop;
  assign err_cnt_clear = in_snoop;
  assign brs_override  = brsd_q;
  assign single_shot   = dar_q;
  assign pee_disable   = dpee_q;

  assign rdata = {8'h00, abr_q, sbr_q, dpee_q, dar_q, brsd_q, snoop_q, lback_q, sleep_q};
endmodule

// File: rtl/can_mode_ctrl_chk.sv
module can_mode_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        core_en,
  input logic        sw_rst,
  input logic        bus_off,
  input logic        wake,
  input logic [15:0] rdata,
  input logic [2:0]  mode,
  input logic        illegal_mode,
  input logic        tx_recessive,
  input logic        ack_suppress,
  input logic        err_cnt_clear,
  input logic        rec_done
);
  AST_SWRST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    sw_rst |=> rdata == 16'h0000); // R1
  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[15:8] == 8'h00); // R1
  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (core_en && !sw_rst) |=> (rdata[5:1] == $past(rdata[5:1]) && rdata[7] == $past(rdata[7]))); // R2
  AST_WAKE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    wake |=> !rdata[0]); // R3
  AST_SBR_NEEDS_BUSOFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_off || !core_en) |=> !rdata[6]); // R4
  AST_ILLEGAL_CFG: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(rdata[2:0]) > 1) |-> (illegal_mode && mode == 3'd0)); // R6
  AST_SNOOP_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd4) |-> (tx_recessive && ack_suppress && err_cnt_clear)); // R7
  AST_DONE_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    rec_done |-> $past(bus_off && core_en && (rdata[7] || rdata[6]))); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rec_done |=> (!rec_done && !rdata[6])); // R10
endmodule

bind can_mode_ctrl can_mode_ctrl_chk chk (
  .clk(clk), .rst_n(rst_n), .core_en(core_en), .sw_rst(sw_rst),
  .bus_off(bus_off), .wake(wake), .rdata(rdata), .mode(mode),
  .illegal_mode(illegal_mode), .tx_recessive(tx_recessive),
  .ack_suppress(ack_suppress), .err_cnt_clear(err_cnt_clear),
  .rec_done(rec_done)
);

// File: tb/can_mode_ctrl_test.sv
module can_mode_ctrl_test;
  localparam int IDLE = 3;
  localparam int SEQS = 4;

  logic clk = 0, rst_n = 0, core_en = 0, sw_rst = 0, bus_off = 0, wake = 0;
  logic rx_bit = 1, bit_tick = 0, wr_en = 0;
  logic [15:0] wdata = '0, rdata;
  logic [2:0] mode;
  logic illegal_mode, tx_recessive, ack_suppress, err_cnt_clear;
  logic brs_override, single_shot, pee_disable, rec_active, rec_done;
  int checks = 0, fails = 0;
  bit done_flag = 0;

  always #4 clk = ~clk;

  can_mode_ctrl #(.IDLE_BITS(IDLE), .REC_SEQS(SEQS)) uut (
    .clk(clk), .rst_n(rst_n), .core_en(core_en), .sw_rst(sw_rst),
    .bus_off(bus_off), .wake(wake), .rx_bit(rx_bit), .bit_tick(bit_tick),
    .wr_en(wr_en), .wdata(wdata), .rdata(rdata), .mode(mode),
    .illegal_mode(illegal_mode), .tx_recessive(tx_recessive),
    .ack_suppress(ack_suppress), .err_cnt_clear(err_cnt_clear),
    .brs_override(brs_override), .single_shot(single_shot),
    .pee_disable(pee_disable), .rec_active(rec_active), .rec_done(rec_done));

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] v);
    wr_en = 1; wdata = {8'h00, v}; step(); wr_en = 0;
  endtask

  task automatic feed(logic b, logic exp_done, string tag);
    rx_bit = b; bit_tick = 1; step(); bit_tick = 0;
    chk(tag, rec_done, exp_done);
  endtask

  function automatic logic [2:0] exp_mode(logic [7:0] r, logic ce);
    int n = int'(r[0]) + int'(r[1]) + int'(r[2]);
    if (!ce || n > 1) return 3'd0;
    if (r[0]) return 3'd2;
    if (r[1]) return 3'd3;
    if (r[2]) return 3'd4;
    return 3'd1;
  endfunction

  initial begin
    logic [7:0] e;
    repeat (3) step();
    rst_n = 1; step();
    chk("R1 reset value", rdata, 16'h0000);
    chk("R5 reset mode", mode, 3'd0);

    e = 8'h00;
    for (int v = 0; v < 256; v++) begin
      for (int k = 0; k < 4; k++) begin
        logic ce, bo;
        logic [7:0] vb;
        ce = k[1]; bo = k[0]; vb = 8'(v);
        core_en = ce; bus_off = bo;
        wr_en = 1; wdata = {8'hA5, vb}; step(); wr_en = 0;
        if (!ce) begin e[5:1] = vb[5:1]; e[7] = vb[7]; end
        e[0] = vb[0];
        e[6] = (bo && ce) ? vb[6] : 1'b0;
        chk("R2 R3 R4 register sweep", rdata, {8'h00, e});
        chk("R5 R6 mode decode", mode, exp_mode(e, ce));
        chk("R6 illegal flag", illegal_mode, (int'(e[0]) + int'(e[1]) + int'(e[2])) > 1);
        chk("R7 snoop strobes", {tx_recessive, ack_suppress, err_cnt_clear},
            (exp_mode(e, ce) == 3'd4) ? 3'b111 : 3'b000);
        chk("R8 option strobes", {pee_disable, single_shot, brs_override}, e[5:3]);
        chk("R9 no done during sweep", rec_done, 1'b0);
      end
    end

    bus_off = 0; core_en = 0; wr(8'hBF);
    chk("R2 load before soft reset", rdata, 16'h00BF);
    sw_rst = 1; step(); sw_rst = 0;
    chk("R1 soft reset clears", rdata, 16'h0000);

    core_en = 1; wr(8'h01);
    chk("R3 sleep written with core enabled", rdata[0], 1'b1);
    chk("R5 sleep mode", mode, 3'd2);
    wake = 1; step(); wake = 0;
    chk("R3 wake clears sleep", rdata[0], 1'b0);
    wake = 1; wr(8'h01); wake = 0;
    chk("R3 wake wins over write", rdata[0], 1'b0);

    bus_off = 1; wr(8'h40);
    chk("R4 manual recovery written in bus-off", rdata[6], 1'b1);
    core_en = 0; step();
    chk("R4 core disable clears manual recovery", rdata[6], 1'b0);

    sw_rst = 1; step(); sw_rst = 0;
    core_en = 0; bus_off = 0; wr(8'h80);
    core_en = 1; bus_off = 1; step();
    chk("R9 auto recovery active", rec_active, 1'b1);
    for (int i = 0; i < IDLE; i++) feed(1'b1, 1'b0, "R10 first run");
    for (int i = 0; i < IDLE - 1; i++) feed(1'b1, 1'b0, "R10 partial run");
    feed(1'b0, 1'b0, "R10 dominant restarts run");
    for (int i = 0; i < (SEQS - 1) * IDLE; i++)
      feed(1'b1, i == (SEQS - 1) * IDLE - 1, "R9 R10 auto recovery done");
    step();
    chk("R10 done is one cycle", rec_done, 1'b0);
    bus_off = 0; step();

    sw_rst = 1; step(); sw_rst = 0;
    core_en = 1; bus_off = 1; step();
    chk("R9 idle without request", rec_active, 1'b0);
    for (int i = 0; i < 2 * SEQS * IDLE; i++) feed(1'b1, 1'b0, "R9 no request no done");
    wr(8'h40);
    chk("R4 manual request set", rdata, 16'h0040);
    for (int i = 0; i < SEQS * IDLE; i++)
      feed(1'b1, i == SEQS * IDLE - 1, "R10 manual recovery done");
    step();
    chk("R10 manual request self-clears", rdata[6], 1'b0);
    chk("R10 done pulse ended", rec_done, 1'b0);
    bus_off = 0; step();

    if (!done_flag) begin
      done_flag = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      done_flag = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule